// File: doc/BRIEF.md
# Half-Bridge Protection and Fault Latch Controller

This block sits between a serial control front end and the gate drivers of three half-bridges. Each committed 16-bit control word gives on/off requests for six switches, a low-side and a high-side switch for each bridge, plus a status-clear bit and an overcurrent response mode. The block turns these requests into gate enables. On the way it applies overrides from digital fault flags: supply undervoltage, per-switch overcurrent, per-switch open load, a thermal prewarning and a thermal shutdown. The fault flags come from external comparators. The undervoltage, overcurrent and open-load flags must persist for their own delay before they count, and each delay timer starts again whenever its flag drops early.

Each fault follows its own latching rule. Undervoltage turns all gates off and they come back as soon as the undervoltage clears. Overcurrent either shuts down the affected switch or is only reported, depending on the mode bit in the control word. A shutdown switch stays off until a status clear. Thermal shutdown turns everything off and clears only when the die has cooled and a status clear is written. A 16-bit status word reports the thermal warning, the real state of each gate, and the sticky supply-fail, open-load and short-circuit flags.

The block also keeps the two switches of a bridge from conducting at the same time. When a bridge reverses direction, a dead-time interval holds both sides off. Pulling the run input low clears everything, and raising it again starts the block from its power-up state.

Top module: `hbridge_guard`

## Requirements
- R1: After reset, and after run_en rises again, all six switch requests are off, all gates are off and status_word is 0. The overcurrent shutdown mode defaults to on.
- R2: On cmd_valid the switch requests are taken from cmd_word bits 1..6 in the order bridge1-low, bridge1-high, bridge2-low, bridge2-high, bridge3-low, bridge3-high. A gate follows its request on the second rising edge after the commit edge. A bridge with both sides requested drives neither side.
- R3: The two gates of one bridge are never high together. When a bridge changes from one side to the other, both gates stay low for exactly DEAD_CYC cycles. Turning the same side back on needs no gap.
- R4: status_word bits 1..6 always equal the six gate outputs, in the R2 order.
- R5: A fault flag that drops before its delay has elapsed has no effect, and its timer starts again from zero.
- R6: uv_flag held for UV_DLY cycles turns all gates off and sets status bit 15. The gates come back without software action once the flag clears. Bit 15 stays set.
- R7: ol_flag on a switch whose gate is on, held for OL_DLY cycles, sets status bit 14 and leaves the gates alone. The flag has no effect on a switch that is off.
- R8: With cmd_word bit 13 set, oc_flag on an on switch held for OC_DLY cycles turns that switch off and sets status bit 13. The switch stays off until a status clear.
- R9: With cmd_word bit 13 clear, a qualified overcurrent sets status bit 13 and the gates stay on.
- R10: A commit with cmd_word bit 0 set clears status bits 13..15 and any overcurrent shutdowns. It does not change the switch requests. A fault still qualified on the commit edge keeps its bit set.
- R11: hot_flag turns all gates off. They return only after a status clear written while hot_flag is low.
- R12: status bit 0 follows warn_flag one cycle later, is not latched, and is not affected by a status clear.
- R13: While run_en is low, the gates and status_word are 0 and commits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_en | input | 1 | High for normal operation; low for standby, which holds the block in reset |
| cmd_valid | input | 1 | One-cycle strobe that commits cmd_word |
| cmd_word | input | 16 | Control word: bit 0 clears status, bits 1..6 are switch requests, bit 13 selects overcurrent shutdown |
| uv_flag | input | 1 | Supply undervoltage comparator |
| oc_flag | input | 6 | Per-switch overcurrent comparator |
| ol_flag | input | 6 | Per-switch open-load (current below threshold) comparator |
| warn_flag | input | 1 | Thermal prewarning comparator, with hysteresis |
| hot_flag | input | 1 | Thermal shutdown comparator, with hysteresis |
| gate_lo | output | 3 | Low-side gate enables, one per bridge |
| gate_hi | output | 3 | High-side gate enables, one per bridge |
| status_word | output | 16 | Thermal warning, gate states and sticky fault flags |

## Verification
The assertions assume that every comparator flag is already synchronous to clk and that cmd_valid is a one-cycle strobe. They also assume DEAD_CYC and each qualification delay are at least 1. The bench drives all inputs on the falling edge and holds each fault flag for a whole number of cycles. Before it issues a status clear, it releases a fault flag at least one cycle ahead of the clear, except in the one case that exercises set-wins priority. It sweeps all 64 switch request patterns starting from a settled all-off state, so that the dead-time rule does not mask the decode.

// File: rtl/hbg_pkg.sv
// Package: shared sizes, field positions and the bridge side type for the
// half-bridge protection controller. Field positions are fixed because
// the serial front end places bits at these offsets.
package hbg_pkg;
    localparam int NUM_BRIDGES = 3;
    localparam int NUM_SW      = 2 * NUM_BRIDGES;
    localparam int WORD_W      = 16;

    // control word fields
    localparam int CTL_CLR    = 0;
    localparam int CTL_SW_LSB = 1;
    localparam int CTL_OCS    = 13;

    // status word fields
    localparam int ST_WARN   = 0;
    localparam int ST_SW_LSB = 1;
    localparam int ST_SHORT  = 13;
    localparam int ST_OPEN   = 14;
    localparam int ST_SUPPLY = 15;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_LO   = 2'd1,
        SIDE_HI   = 2'd2
    } side_e;
endpackage

// File: rtl/fault_qualifier.sv
// fault_qualifier: reports a fault only after its condition has held for
// DLY consecutive cycles. Any cycle without the condition restarts the
// count. Assumes cond is synchronous to clk and DLY >= 1.
module fault_qualifier #(
    parameter int DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic qual
);
    localparam int CNT_W = $clog2(DLY + 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DLY);

    logic [CNT_W-1:0] cnt;

    // count consecutive cycles of the condition, saturate at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!cond) begin
            cnt <= '0;
        end else if (cnt != LIMIT) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual = (cnt == LIMIT);

    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt == '0));
    assert_qual_needs_cond_R5: assert property (@(posedge clk) disable iff (!rst_n)
        qual |-> $past(cond));
endmodule

// File: rtl/bridge_lockout.sv
// bridge_lockout: turns the low/high requests of one half-bridge into
// registered gate enables. It refuses both sides at once and enforces
// DEAD_CYC idle cycles before the opposite side may turn on. Assumes
// DEAD_CYC >= 1.
module bridge_lockout
    import hbg_pkg::*;
#(
    parameter int DEAD_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_lo,
    input  logic req_hi,
    output logic gate_lo,
    output logic gate_hi
);
    localparam int GAP_W = $clog2(DEAD_CYC + 1);
    localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(DEAD_CYC);

    side_e            last_side;
    logic [GAP_W-1:0] gap;
    logic             gap_done;
    logic             grant_lo;
    logic             grant_hi;

    // a side may turn on if it was the last side used or the gap has elapsed
    always_comb begin
        gap_done = (gap == GAP_LIM);
        grant_lo = req_lo && !req_hi && (last_side != SIDE_HI || gap_done);
        grant_hi = req_hi && !req_lo && (last_side != SIDE_LO || gap_done);
    end

    // register gates, remember the last side and count idle cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_lo   <= 1'b0;
            gate_hi   <= 1'b0;
            last_side <= SIDE_NONE;
            gap       <= '0;
        end else begin
            gate_lo <= grant_lo;
            gate_hi <= grant_hi;
            if (grant_lo) begin
                last_side <= SIDE_LO;
            end else if (grant_hi) begin
                last_side <= SIDE_HI;
            end
            if (grant_lo || grant_hi) begin
                gap <= '0;
            end else if (!gap_done) begin
                gap <= gap + 1'b1;
            end
        end
    end

    assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate_lo && gate_hi));
    assert_hi_after_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_hi |-> !$past(gate_lo));
    assert_lo_after_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        gate_lo |-> !$past(gate_hi));
endmodule

// File: rtl/fault_latches.sv
// fault_latches: sticky fault state. It holds the supply-fail, open-load
// and short flags, the per-switch overcurrent trips and the thermal
// shutdown latch. A set on the same edge as a clear wins. The thermal
// latch clears only when the shutdown comparator is low.
module fault_latches
    import hbg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              uv_q,
    input  logic [NUM_SW-1:0] oc_q,
    input  logic [NUM_SW-1:0] ol_q,
    input  logic              ocs_mode,
    input  logic              hot,
    output logic              supply_fail,
    output logic              open_load,
    output logic              short_seen,
    output logic [NUM_SW-1:0] trip,
    output logic              hot_lat
);
    // update every sticky flag: set term OR (old value AND NOT clear)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            supply_fail <= 1'b0;
            open_load   <= 1'b0;
            short_seen  <= 1'b0;
            trip        <= '0;
            hot_lat     <= 1'b0;
        end else begin
            supply_fail <= uv_q | (supply_fail & ~clr);
            open_load   <= (|ol_q) | (open_load & ~clr);
            short_seen  <= (|oc_q) | (short_seen & ~clr);
            trip        <= (oc_q & {NUM_SW{ocs_mode}}) | (trip & ~{NUM_SW{clr}});
            hot_lat     <= hot | (hot_lat & ~clr);
        end
    end

    assert_supply_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(supply_fail) |-> ($past(clr) || !$past(rst_n)));
    assert_open_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(open_load) |-> ($past(clr) || !$past(rst_n)));
    assert_short_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(short_seen) |-> ($past(clr) || !$past(rst_n)));
    assert_supply_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uv_q |=> supply_fail);
    assert_hot_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hot_lat) |-> ($past(clr) && !$past(hot)) || !$past(rst_n));
endmodule

// File: rtl/hbridge_guard.sv
// hbridge_guard: top of the half-bridge protection controller. It holds
// the committed control word, qualifies fault flags with delay timers,
// applies the protection overrides to the switch requests, drives three
// lockout-protected bridges and assembles the status word. Assumes all
// flags are synchronous to clk and cmd_valid is a one-cycle strobe.
// A low run_en acts as reset.
module hbridge_guard
    import hbg_pkg::*;
#(
    parameter int UV_DLY   = 8,
    parameter int OC_DLY   = 6,
    parameter int OL_DLY   = 20,
    parameter int DEAD_CYC = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   run_en,
    input  logic                   cmd_valid,
    input  logic [WORD_W-1:0]      cmd_word,
    input  logic                   uv_flag,
    input  logic [NUM_SW-1:0]      oc_flag,
    input  logic [NUM_SW-1:0]      ol_flag,
    input  logic                   warn_flag,
    input  logic                   hot_flag,
    output logic [NUM_BRIDGES-1:0] gate_lo,
    output logic [NUM_BRIDGES-1:0] gate_hi,
    output logic [WORD_W-1:0]      status_word
);
    logic              run_rst_n;
    logic [NUM_SW-1:0] ctrl_sw;
    logic              ocs_mode;
    logic              warn_q;
    logic              clr;
    logic [NUM_SW-1:0] sw_on;
    logic [NUM_SW-1:0] req;
    logic              uv_q;
    logic [NUM_SW-1:0] oc_q;
    logic [NUM_SW-1:0] ol_q;
    logic              supply_fail;
    logic              open_load;
    logic              short_seen;
    logic [NUM_SW-1:0] trip;
    logic              hot_lat;
    logic              unused_ctl_bits;

    assign run_rst_n       = rst_n & run_en;
    assign clr             = cmd_valid & cmd_word[CTL_CLR];
    assign unused_ctl_bits = ^{cmd_word[WORD_W-1:CTL_OCS+1],
                               cmd_word[CTL_OCS-1:CTL_SW_LSB+NUM_SW]};

    // control register and warning sample; power-up value has shutdown mode on
    always_ff @(posedge clk) begin
        if (!run_rst_n) begin
            ctrl_sw  <= '0;
            ocs_mode <= 1'b1;
            warn_q   <= 1'b0;
        end else begin
            warn_q <= warn_flag;
            if (cmd_valid) begin
                ctrl_sw  <= cmd_word[CTL_SW_LSB +: NUM_SW];
                ocs_mode <= cmd_word[CTL_OCS];
            end
        end
    end

    fault_qualifier #(.DLY(UV_DLY)) u_uv_qual (
        .clk  (clk),
        .rst_n(run_rst_n),
        .cond (uv_flag),
        .qual (uv_q)
    );

    for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
        fault_qualifier #(.DLY(OC_DLY)) u_oc_qual (
            .clk  (clk),
            .rst_n(run_rst_n),
            .cond (oc_flag[s] & sw_on[s]),
            .qual (oc_q[s])
        );
        fault_qualifier #(.DLY(OL_DLY)) u_ol_qual (
            .clk  (clk),
            .rst_n(run_rst_n),
            .cond (ol_flag[s] & sw_on[s]),
            .qual (ol_q[s])
        );

        // a request survives only without trip, undervoltage or thermal latch
        assign req[s] = ctrl_sw[s] & ~trip[s] & ~uv_q & ~hot_lat;

        assert_trip_off_R8: assert property (@(posedge clk) disable iff (!run_rst_n)
            trip[s] |=> !sw_on[s]);
    end

    fault_latches u_latches (
        .clk        (clk),
        .rst_n      (run_rst_n),
        .clr        (clr),
        .uv_q       (uv_q),
        .oc_q       (oc_q),
        .ol_q       (ol_q),
        .ocs_mode   (ocs_mode),
        .hot        (hot_flag),
        .supply_fail(supply_fail),
        .open_load  (open_load),
        .short_seen (short_seen),
        .trip       (trip),
        .hot_lat    (hot_lat)
    );

    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_bridge
        bridge_lockout #(.DEAD_CYC(DEAD_CYC)) u_lockout (
            .clk    (clk),
            .rst_n  (run_rst_n),
            .req_lo (req[2*b]),
            .req_hi (req[2*b+1]),
            .gate_lo(gate_lo[b]),
            .gate_hi(gate_hi[b])
        );
        assign sw_on[2*b]   = gate_lo[b];
        assign sw_on[2*b+1] = gate_hi[b];
    end

    // assemble the status word from live gates and sticky flags
    always_comb begin
        status_word                         = '0;
        status_word[ST_WARN]                = warn_q;
        status_word[ST_SW_LSB +: NUM_SW]    = sw_on;
        status_word[ST_SHORT]               = short_seen;
        status_word[ST_OPEN]                = open_load;
        status_word[ST_SUPPLY]              = supply_fail;
    end

    assert_uv_off_R6: assert property (@(posedge clk) disable iff (!run_rst_n)
        uv_q |=> (sw_on == '0));
    assert_hot_off_R11: assert property (@(posedge clk) disable iff (!run_rst_n)
        hot_lat |=> (sw_on == '0));
    assert_standby_clear_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (status_word == '0));
endmodule

// File: tb/hbridge_guard_tb.sv
// Bench for hbridge_guard: drives on the falling edge and samples there.
module hbridge_guard_tb_top;
    localparam int UV_DLY   = 8;
    localparam int OC_DLY   = 6;
    localparam int OL_DLY   = 20;
    localparam int DEAD_CYC = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        uv_flag = 1'b0;
    logic [5:0]  oc_flag = '0;
    logic [5:0]  ol_flag = '0;
    logic        warn_flag = 1'b0;
    logic        hot_flag = 1'b0;
    logic [2:0]  gate_lo;
    logic [2:0]  gate_hi;
    logic [15:0] status_word;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hbridge_guard #(
        .UV_DLY(UV_DLY), .OC_DLY(OC_DLY), .OL_DLY(OL_DLY), .DEAD_CYC(DEAD_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .cmd_valid(cmd_valid),
        .cmd_word(cmd_word), .uv_flag(uv_flag), .oc_flag(oc_flag),
        .ol_flag(ol_flag), .warn_flag(warn_flag), .hot_flag(hot_flag),
        .gate_lo(gate_lo), .gate_hi(gate_hi), .status_word(status_word)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // control word: bit0 clear, bits1..6 switches, bit13 shutdown mode
    function automatic logic [15:0] mk(input logic [5:0] sw, input logic ocs, input logic clr);
        return {2'b00, ocs, 6'b000000, sw, clr};
    endfunction

    // gates interleaved in R2 order: low then high per bridge
    function automatic logic [15:0] gates();
        logic [15:0] v = '0;
        for (int b = 0; b < 3; b++) begin
            v[2*b]   = gate_lo[b];
            v[2*b+1] = gate_hi[b];
        end
        return v;
    endfunction

    function automatic logic [15:0] decode(input logic [5:0] p);
        logic [15:0] v = '0;
        for (int b = 0; b < 3; b++) begin
            v[2*b]   = p[2*b] & ~p[2*b+1];
            v[2*b+1] = p[2*b+1] & ~p[2*b];
        end
        return v;
    endfunction

    task automatic commit(input logic [15:0] w);
        cmd_valid = 1'b1;
        cmd_word  = w;
        tick(1);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        check("R1 reset status", status_word, 16'h0000);
        check("R1 reset gates", gates(), 16'h0000);

        // R2 and R4: every request pattern from a settled all-off state
        for (int p = 0; p < 64; p++) begin
            commit(mk(6'd0, 1'b1, 1'b0));
            tick(DEAD_CYC + 2);
            commit(mk(6'(p), 1'b1, 1'b0));
            tick(1);
            check("R2 decode", gates(), decode(6'(p)));
            check("R4 status gates", status_word, decode(6'(p)) << 1);
        end

        // R3: reversal low->high then high->low, then same-side reuse
        commit(mk(6'd0, 1'b1, 1'b0));
        tick(DEAD_CYC + 2);
        commit(mk(6'b000001, 1'b1, 1'b0));
        tick(1);
        check("R3 start low", gates(), 16'h0001);
        commit(mk(6'b000010, 1'b1, 1'b0));
        check("R3 low held first cycle", gates(), 16'h0001);
        for (int k = 0; k < DEAD_CYC; k++) begin
            tick(1);
            check("R3 dead gap lo->hi", gates(), 16'h0000);
        end
        tick(1);
        check("R3 high after gap", gates(), 16'h0002);
        commit(mk(6'b000001, 1'b1, 1'b0));
        check("R3 high held first cycle", gates(), 16'h0002);
        for (int k = 0; k < DEAD_CYC; k++) begin
            tick(1);
            check("R3 dead gap hi->lo", gates(), 16'h0000);
        end
        tick(1);
        check("R3 low after gap", gates(), 16'h0001);
        commit(mk(6'd0, 1'b1, 1'b0));
        commit(mk(6'b000001, 1'b1, 1'b0));
        tick(1);
        check("R3 same side no gap", gates(), 16'h0001);

        // R5: short undervoltage pulses restart the timer
        uv_flag = 1'b1; tick(UV_DLY - 1);
        uv_flag = 1'b0; tick(1);
        uv_flag = 1'b1; tick(UV_DLY - 1);
        uv_flag = 1'b0; tick(2);
        check("R5 short uv ignored", status_word, 16'h0002);

        // R6: qualified undervoltage, automatic recovery, sticky flag
        uv_flag = 1'b1; tick(UV_DLY + 1);
        check("R6 uv gates off", gates(), 16'h0000);
        check("R6 uv flag set", status_word, 16'h8000);
        uv_flag = 1'b0; tick(2);
        check("R6 uv recover sticky", status_word, 16'h8002);
        commit(mk(6'b000001, 1'b1, 1'b1));
        check("R10 clear supply flag", status_word, 16'h0002);

        // R7: open load on an off switch, then on the on switch
        ol_flag = 6'b000010; tick(OL_DLY + 3);
        check("R7 open load on off switch", status_word, 16'h0002);
        ol_flag = 6'b000001; tick(OL_DLY + 1);
        check("R7 open load set", status_word, 16'h4002);
        ol_flag = 6'b000000; tick(2);
        check("R7 open load sticky", status_word, 16'h4002);
        commit(mk(6'b000001, 1'b1, 1'b1));
        check("R10 clear open load", status_word, 16'h0002);

        // R8: shutdown mode trips only the shorted switch
        commit(mk(6'b000101, 1'b1, 1'b0));
        tick(1);
        check("R8 two lows on", status_word, 16'h000A);
        oc_flag = 6'b000100; tick(OC_DLY + 2);
        check("R8 shorted switch off", status_word, 16'h2002);
        check("R8 other gate on", gates(), 16'h0001);
        oc_flag = 6'b000000; tick(3);
        check("R8 stays off until clear", status_word, 16'h2002);
        commit(mk(6'b000101, 1'b1, 1'b1));
        tick(1);
        check("R10 clear re-enables", status_word, 16'h000A);

        // R9: report-only mode keeps gates on
        commit(mk(6'b000101, 1'b0, 1'b0));
        tick(1);
        oc_flag = 6'b000100; tick(OC_DLY + 2);
        check("R9 report only", status_word, 16'h200A);
        tick(5);
        check("R9 gates stay on", gates(), 16'h0005);
        commit(mk(6'b000101, 1'b0, 1'b1));
        check("R10 set wins over clear", status_word, 16'h200A);
        oc_flag = 6'b000000; tick(1);
        commit(mk(6'b000101, 1'b0, 1'b1));
        check("R10 short cleared", status_word, 16'h000A);

        // R11: thermal shutdown needs cooling and a clear
        hot_flag = 1'b1; tick(2);
        check("R11 hot all off", status_word, 16'h0000);
        hot_flag = 1'b0; tick(3);
        check("R11 cooled without clear", status_word, 16'h0000);
        hot_flag = 1'b1;
        commit(mk(6'b000101, 1'b1, 1'b1));
        tick(2);
        check("R11 clear while hot", status_word, 16'h0000);
        hot_flag = 1'b0; tick(1);
        commit(mk(6'b000101, 1'b1, 1'b1));
        tick(1);
        check("R11 restored", status_word, 16'h000A);

        // R12: warning follows comparator, immune to clear
        warn_flag = 1'b1; tick(1);
        check("R12 warn set", status_word, 16'h000B);
        commit(mk(6'b000101, 1'b1, 1'b1));
        check("R12 warn survives clear", status_word, 16'h000B);
        warn_flag = 1'b0; tick(1);
        check("R12 warn follows", status_word, 16'h000A);

        // R13: standby wipes everything and ignores commits
        uv_flag = 1'b1; tick(UV_DLY + 1);
        uv_flag = 1'b0; tick(2);
        check("R6 before standby", status_word, 16'h800A);
        run_en = 1'b0; tick(1);
        check("R13 standby status", status_word, 16'h0000);
        check("R13 standby gates", gates(), 16'h0000);
        commit(mk(6'b000101, 1'b1, 1'b0));
        tick(1);
        check("R13 commit ignored", status_word, 16'h0000);
        run_en = 1'b1; tick(3);
        check("R1 power-up after standby", status_word, 16'h0000);
        commit(mk(6'b000101, 1'b1, 1'b0));
        tick(1);
        check("R13 operates after wake", status_word, 16'h000A);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule